// File: doc/BRIEF.md
# Byte-Wide SPI Master with Double-Buffered Transmit

This block is a three-wire SPI master. Each transfer moves one byte in each direction. Writing a byte to the data port starts a transfer. The byte first lands in a holding buffer and then moves into a shift register. While that byte shifts out on `mosi`, a byte from the slave shifts in on `miso`. The serial clock is paced by the `sckEn` input, which pulses once per SCK half-period. The SCK idle level, the sampling edge and the bit order can each be chosen. There is no slave-select logic: a system that needs one drives it from general-purpose logic.

The holding buffer empties as soon as its byte moves into the shifter. A transmit-ready interrupt then pulses, roughly eight bit periods before the receive interrupt of the same byte. Software can therefore queue the next byte while the current one is still on the wire. When the current byte finishes, a queued byte starts in the same cycle, so back-to-back bytes run without the master going idle. When the transfer ends, the received byte appears on `rdData` and the receive interrupt pulses.

Top module: `spi_byte_master`

## Requirements
- R1: When the block is idle, a write on `wrEn` starts a transfer. `busy` reads 1 and `txReadyIrq` pulses for one cycle in the second cycle after the write edge.
- R2: `busy` stays high while bits are shifting. It falls in the same cycle that `rxReadyIrq` pulses if no byte is queued, and it never falls at any other time.
- R3: `byteDone` is set when a transfer ends. Any write on `wrEn` clears it; if a write and a transfer end fall in the same cycle, the set wins.
- R4: While idle, `sck` equals `cpol`. Each byte gives exactly eight SCK pulses, and `sck` returns to `cpol` at the end.
- R5: With `cpha`=0, the first data bit is on `mosi` before the first SCK edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With `cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: With `lsbFirst`=1, bit 0 of the byte goes out first and the first received bit becomes bit 0. With `lsbFirst`=0, bit 7 goes first and the first received bit becomes bit 7.
- R7: At the end of a transfer, `rdData` holds the byte sampled from `miso`, and `rxReadyIrq` pulses for one cycle.
- R8: `txReadyIrq` pulses when the byte moves from the holding buffer to the shifter. This is about 16 `sckEn` pulses (eight bit periods) before that byte's `rxReadyIrq`.
- R9: A byte written while a transfer runs and the holding buffer is empty is kept. It starts in the cycle the current byte ends: `busy` stays 1, and `txReadyIrq` and `rxReadyIrq` pulse together. Both bytes arrive intact in either phase setting.
- R10: A write while the holding buffer is already full is dropped. It produces no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sckEn | input | 1 | Pulse that advances SCK by one half-period |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsbFirst | input | 1 | 1: least significant bit first |
| wrEn | input | 1 | Write strobe for the transmit byte |
| wrData | input | 8 | Byte to transmit |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| rdData | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| byteDone | output | 1 | Sticky end-of-transfer flag |
| txReadyIrq | output | 1 | One-cycle pulse: holding buffer free again |
| rxReadyIrq | output | 1 | One-cycle pulse: new byte on `rdData` |

## Verification
The assertions check the following on every cycle:
- `busy` never drops without a receive pulse.
- A transmit pulse only appears while busy.
- SCK is at its idle level whenever the block is not busy.
- The done flag is set alongside every receive pulse.
- A queued byte always restarts the shifter directly from the end cycle.
- `mosi` never moves outside a launch point.

Only the scenarios can show whether the bits are correct. A bench slave model captures `mosi` on its own edge choice and returns known bytes. This exposes sampling-edge, bit-order and corruption faults in all four clock modes. The scenarios also show that a write to a full holding buffer is dropped, and they measure the gap between the transmit and receive interrupts.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_FINISH = 2'd2
  } spimState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadHold;   // capture wrData into the holding buffer
    logic startXfer;  // move holding buffer into the shifter
    logic driveBit;   // launch the next bit on mosi
    logic sampleBit;  // capture miso
    logic finish;     // publish the received byte
  } spimStrobe_t;

endpackage

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckEn,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        wrEn,
  output spimStrobe_t strb,
  output logic        sck,
  output logic        busy,
  output logic        byteDone,
  output logic        txReadyIrq,
  output logic        rxReadyIrq
);

  localparam int EdgeN = 2 * DataW;
  localparam int CntW  = $clog2(EdgeN);
  localparam logic [CntW-1:0] LastEdge = CntW'(EdgeN - 1);

  spimState_t      state;
  logic [CntW-1:0] edgeCnt;
  logic            sckPhase;
  logic            holdValid;
  logic            busyQ;
  logic            doneQ;
  logic            txIrqQ;
  logic            rxIrqQ;

  logic wrAccept;
  logic startNow;
  logic edgeNow;
  logic leading;
  logic lastEdge;

  always_comb begin
    wrAccept = wrEn && !holdValid;
    startNow = holdValid && (state != ST_SHIFT);
    edgeNow  = (state == ST_SHIFT) && sckEn;
    leading  = !edgeCnt[0];
    lastEdge = (edgeCnt == LastEdge);

    strb.loadHold  = wrAccept;
    strb.startXfer = startNow;
    strb.sampleBit = edgeNow && (cpha ? !leading : leading);
    strb.driveBit  = edgeNow && (cpha ? leading : (!leading && !lastEdge));
    strb.finish    = (state == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   if (startNow) state <= ST_SHIFT;
        ST_SHIFT:  if (edgeNow && lastEdge) state <= ST_FINISH;
        ST_FINISH: state <= startNow ? ST_SHIFT : ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt  <= '0;
      sckPhase <= 1'b0;
    end else if (startNow) begin
      edgeCnt  <= '0;
      sckPhase <= 1'b0;
    end else if (edgeNow) begin
      edgeCnt  <= edgeCnt + 1'b1;
      sckPhase <= ~sckPhase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      txIrqQ    <= 1'b0;
      rxIrqQ    <= 1'b0;
    end else begin
      if (wrAccept)      holdValid <= 1'b1;
      else if (startNow) holdValid <= 1'b0;

      if (startNow)         busyQ <= 1'b1;
      else if (strb.finish) busyQ <= 1'b0;

      if (strb.finish) doneQ <= 1'b1;
      else if (wrEn)   doneQ <= 1'b0;

      txIrqQ <= startNow;
      rxIrqQ <= strb.finish;
    end
  end

  assign sck        = sckPhase ^ cpol;
  assign busy       = busyQ;
  assign byteDone   = doneQ;
  assign txReadyIrq = txIrqQ;
  assign rxReadyIrq = rxIrqQ;

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> rxIrqQ);

  // R8
  tx_irq_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrqQ |-> busyQ);

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> (sckPhase == 1'b0));

  // R3
  done_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrqQ |-> doneQ);

  // R9
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH && holdValid) |=> (busyQ && state == ST_SHIFT));

endmodule

// File: rtl/spim_dpath.sv
`timescale 1ns/1ps
module spim_dpath
  import spim_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  spimStrobe_t      strb,
  input  logic             cpha,
  input  logic             lsbFirst,
  input  logic [DataW-1:0] wrData,
  input  logic             miso,
  output logic             mosi,
  output logic [DataW-1:0] rdData
);

  logic [DataW-1:0] holdData;
  logic [DataW-1:0] txSh;
  logic [DataW-1:0] rxSh;
  logic [DataW-1:0] rdQ;
  logic             mosiQ;

  function automatic logic headBit(input logic [DataW-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DataW-1];
  endfunction

  function automatic logic [DataW-1:0] dropHead(input logic [DataW-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdData <= '0;
    else if (strb.loadHold) holdData <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      mosiQ <= 1'b0;
    end else if (strb.startXfer) begin
      if (!cpha) begin
        mosiQ <= headBit(holdData, lsbFirst);
        txSh  <= dropHead(holdData, lsbFirst);
      end else begin
        txSh  <= holdData;
      end
    end else if (strb.driveBit) begin
      mosiQ <= headBit(txSh, lsbFirst);
      txSh  <= dropHead(txSh, lsbFirst);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
      rdQ  <= '0;
    end else begin
      if (strb.sampleBit) begin
        if (lsbFirst) rxSh <= {miso, rxSh[DataW-1:1]};
        else          rxSh <= {rxSh[DataW-2:0], miso};
      end
      if (strb.finish) rdQ <= rxSh;
    end
  end

  assign mosi   = mosiQ;
  assign rdData = rdQ;

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.startXfer || strb.driveBit) |=> $stable(mosiQ));

endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckEn,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsbFirst,
  input  logic             wrEn,
  input  logic [DataW-1:0] wrData,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic [DataW-1:0] rdData,
  output logic             busy,
  output logic             byteDone,
  output logic             txReadyIrq,
  output logic             rxReadyIrq
);

  spimStrobe_t strb;

  spim_ctrl #(.DataW(DataW)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sckEn      (sckEn),
    .cpol       (cpol),
    .cpha       (cpha),
    .wrEn       (wrEn),
    .strb       (strb),
    .sck        (sck),
    .busy       (busy),
    .byteDone   (byteDone),
    .txReadyIrq (txReadyIrq),
    .rxReadyIrq (rxReadyIrq)
  );

  spim_dpath #(.DataW(DataW)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpha     (cpha),
    .lsbFirst (lsbFirst),
    .wrData   (wrData),
    .miso     (miso),
    .mosi     (mosi),
    .rdData   (rdData)
  );

endmodule

// File: tb/spi_byte_master_tb_top.sv
`timescale 1ns/1ps
module spi_byte_master_tb_top;

  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sckEn = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       lsbFirst = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       miso;
  logic       sck, mosi, busy, byteDone, txReadyIrq, rxReadyIrq;
  logic [7:0] rdData;

  spi_byte_master dut_i (
    .clk(clk), .rstN(rstN), .sckEn(sckEn), .cpol(cpol), .cpha(cpha),
    .lsbFirst(lsbFirst), .wrEn(wrEn), .wrData(wrData), .miso(miso),
    .sck(sck), .mosi(mosi), .rdData(rdData), .busy(busy),
    .byteDone(byteDone), .txReadyIrq(txReadyIrq), .rxReadyIrq(rxReadyIrq)
  );

  always #2.5 clk = ~clk;

  int divCnt = 0;
  always @(negedge clk) begin
    divCnt <= (divCnt == DIV - 1) ? 0 : divCnt + 1;
    sckEn  <= (divCnt == DIV - 1);
  end

  int nChecks = 0;
  int nFails = 0;
  int rxSeen = 0;
  int nAccepted = 0;
  bit finished = 1'b0;
  logic [7:0] txExpQ[$];
  logic [7:0] rxExpQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slaveByte(input int i);
    return 8'(i * 37 + 5) ^ 8'h3C;
  endfunction

  function automatic logic wireBit(input logic [7:0] v, input int k, input logic lsb);
    return lsb ? v[k] : v[7-k];
  endfunction

  // slave model: returns slaveByte(n) for the n-th transfer, captures mosi
  int sBit = 0;
  int capN = 0;
  int sIdx = 0;
  logic [7:0] capByte = '0;
  int misoIdx;
  assign misoIdx = cpha ? ((sBit > 0) ? sBit - 1 : 0) : ((sBit > 7) ? 7 : sBit);
  assign miso = wireBit(slaveByte(sIdx), misoIdx, lsbFirst);

  always @(sck) begin
    if (rstN && busy) begin
      logic lead;
      logic [7:0] expTx;
      lead = (sck != cpol);
      if (lead ^ cpha) begin
        if (lsbFirst) capByte[capN] = mosi;
        else          capByte[7-capN] = mosi;
        capN++;
        if (capN == 8) begin
          capN = 0;
          if (txExpQ.size() == 0) begin
            check(1'b0, "R10 unexpected transfer", capByte, 0);
          end else begin
            expTx = txExpQ.pop_front();
            check(capByte == expTx, "R5 R6 transmitted byte", capByte, expTx);
          end
          if (cpha) begin
            sBit = 0;
            sIdx++;
          end
        end
      end else begin
        sBit++;
        if (!cpha && sBit == 8) begin
          sBit = 0;
          sIdx++;
        end
      end
    end
  end

  // monitor: pops expected received bytes
  always @(negedge clk) begin
    if (rstN && rxReadyIrq) begin
      logic [7:0] expRx;
      rxSeen++;
      if (rxExpQ.size() == 0) begin
        check(1'b0, "R10 extra receive", rdData, 0);
      end else begin
        expRx = rxExpQ.pop_front();
        check(rdData == expRx, "R7 received byte", rdData, expRx);
      end
      check(byteDone == 1'b1, "R3 done set", byteDone, 1);
    end
  end

  task automatic wr(input logic [7:0] b, input bit accepted);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
    if (accepted) begin
      txExpQ.push_back(b);
      rxExpQ.push_back(slaveByte(nAccepted));
      nAccepted++;
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic single(input logic [7:0] b);
    int n;
    waitIdle();
    wr(b, 1'b1);
    check(byteDone == 1'b0, "R3 cleared by write", byteDone, 0);
    @(negedge clk);
    check(txReadyIrq == 1'b1, "R1 R8 tx irq", txReadyIrq, 1);
    check(busy == 1'b1, "R1 busy rises", busy, 1);
    check(sck == cpol, "R4 sck idle before first edge", sck, cpol);
    if (!cpha)
      check(mosi == wireBit(b, 0, lsbFirst), "R5 first bit early", mosi, wireBit(b, 0, lsbFirst));
    n = 0;
    while (!rxReadyIrq && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(n >= 15 * DIV && n <= 17 * DIV + 2, "R8 tx-to-rx gap", n, 16 * DIV);
    check(busy == 1'b0, "R2 busy falls", busy, 0);
    check(sck == cpol, "R4 sck back to idle", sck, cpol);
  endtask

  task automatic burst(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    int n;
    waitIdle();
    wr(a, 1'b1);
    wr(b, 1'b1);
    wr(c, 1'b0);
    n = 0;
    while (!rxReadyIrq && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(busy == 1'b1, "R9 busy stays high", busy, 1);
    check(txReadyIrq == 1'b1, "R9 queued byte starts", txReadyIrq, 1);
    @(negedge clk);
    n = 0;
    while (!rxReadyIrq && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(busy == 1'b0, "R2 busy falls after burst", busy, 0);
    repeat (20 * DIV) @(negedge clk);
    check(busy == 1'b0, "R10 dropped write starts nothing", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 reset busy", busy, 0);
    check(byteDone == 1'b0, "R3 reset done", byteDone, 0);
    check(sck == 1'b0, "R4 reset sck", sck, 0);
    check(txReadyIrq == 1'b0 && rxReadyIrq == 1'b0, "R8 reset irqs", {txReadyIrq, rxReadyIrq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int m = 0; m < 8; m++) begin
      waitIdle();
      cpol = m[0];
      cpha = m[1];
      lsbFirst = m[2];
      @(negedge clk);
      check(sck == cpol, "R4 idle level follows cpol", sck, cpol);
      single(8'hC1 ^ 8'(m * 29));
    end

    cpol = 1'b0; cpha = 1'b0; lsbFirst = 1'b0;
    burst(8'h5A, 8'h81, 8'hFF);
    cpol = 1'b1; cpha = 1'b1; lsbFirst = 1'b1;
    burst(8'h0F, 8'hE4, 8'h33);
    cpol = 1'b0; cpha = 1'b1; lsbFirst = 1'b0;
    single(8'h96);

    waitIdle();
    check(rxSeen == nAccepted, "R10 transfer count", rxSeen, nAccepted);
    check(txExpQ.size() == 0 && rxExpQ.size() == 0, "R7 all bytes seen",
          txExpQ.size() + rxExpQ.size(), 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule